// File: doc/BRIEF.md
# Banked SPI Register Command Interpreter

This block is an SPI slave that turns a stream of command bytes into accesses to a small, banked control-register space. The clock is SPI mode 0 and bits go MSB first. Each chip-select frame begins with an opcode byte, and the opcode decides how many argument bytes follow and what they mean. Short task opcodes pick one of four register banks or flip a control bit. Several of them can be chained inside one frame. A two-byte opcode reports which bank is selected. Three-byte opcodes load or fetch one of six 16-bit pointers. N-byte opcodes read, write, OR into or AND-NOT into byte registers at a 5-bit in-bank address, and the address advances after every data byte.

Each bank holds 16-bit registers at even byte addresses, with the low byte at the even address. The window from byte 0x16 to 0x1F is a single shared set of five words that every bank sees. The core samples SCK, CS_N and MOSI with the system clock, so each SCK phase must last at least six system clock cycles.

Top module: `spi_bank_cmd`

## Requirements
- R1: MOSI is sampled on rising SCK and MISO changes only after falling SCK, MSB first. MISO is 0 during every opcode byte and while chip select is high. The first byte after chip select falls is always decoded as an opcode.
- R2: Opcodes 0xC0, 0xC2, 0xC4 and 0xC6 select bank 0, 1, 2 and 3 and return no data. The next byte of the same frame is a new opcode. The selection lasts across frames, and bank 0 is selected after reset.
- R3: Opcode 0xC8 returns 0xC0 + 2×bank during its second byte. Any later bytes in that frame return 0 and have no effect.
- R4: For an opcode with top three bits 000, the slave returns the byte at address bits [4:0]. For top bits 010, the next byte is stored at that address. Within a 16-bit word, the low byte is at the even address.
- R5: For top bits 100, the data byte is ORed into the addressed byte. For top bits 101, the complement of the data byte is ANDed into it.
- R6: N-byte commands go on for as long as the frame lasts. The address advances by one after each data byte and wraps from 0x1F to 0x16.
- R7: Byte addresses 0x16 to 0x1F reach the same storage from every bank. Addresses 0x00 to 0x15 are private to each bank.
- R8: Each pointer is written by one opcode and read by another: 0x60/0x62, 0x64/0x66, 0x68/0x6A, 0x6C/0x6E, 0x70/0x72 and 0x78/0x76 (write/read). Arguments and results go low byte first. A write takes effect only once both argument bytes have arrived. Bytes after the third return 0 and are ignored.
- R9: Opcode 0xE8 sets bit 0 of the shared byte at 0x1E and opcode 0xEA clears it. Both return no data and can be chained.
- R10: An opcode not named in R2 to R9 makes the rest of its frame return 0 and changes no state.
- R11: After reset, all registers and pointers read 0.
- R12: Raising chip select in the middle of a command drops the partial byte and any pointer argument that is still incomplete. Nothing that has not yet been committed is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sck | input | 1 | SPI serial clock, mode 0 |
| cs_n | input | 1 | SPI chip select, active low, frames one command sequence |
| mosi | input | 1 | Serial data from the master |
| miso | output | 1 | Serial data to the master, held at 0 when not sending |

## Verification
The bench aims at the address wrap from 0x1F back to 0x16. A design that wraps to 0x00 would corrupt private registers, and one that runs on to 0x20 would return garbage. It checks that the shared window is one store by writing it in one bank and reading it in another, while private addresses must stay separate. Aborted frames, a half byte or a pointer that has only its low byte, must leave state untouched; a design that commits early would show the partial value on the next read. Chained bank selects, the swapped read/write opcodes of the last pointer, and unknown opcodes that must neither answer nor write are driven both directed and randomly. Each run ends with a full read-back of all four banks.

// File: rtl/spi_bank_pkg.sv
package spi_bank_pkg;

  localparam logic [7:0] OPC_BANK0   = 8'hC0;
  localparam logic [7:0] OPC_BANKSEL_MASK = 8'hF9;
  localparam logic [7:0] OPC_RDBANK  = 8'hC8;
  localparam logic [7:0] OPC_CTL_SET = 8'hE8;
  localparam logic [7:0] OPC_CTL_CLR = 8'hEA;

  localparam int NUM_PTRS = 6;
  localparam int PIDX_W   = $clog2(NUM_PTRS);

  typedef enum logic [2:0] {
    ST_OPC = 3'd0,
    ST_NB  = 3'd1,
    ST_PLO = 3'd2,
    ST_PHI = 3'd3,
    ST_RBK = 3'd4,
    ST_IGN = 3'd5
  } dec_state_t;

  typedef enum logic [2:0] {
    OP_NONE, OP_RD, OP_WR, OP_SET, OP_CLR, OP_PWR, OP_PRD
  } op_kind_t;

  typedef enum logic [1:0] {
    WM_WRITE, WM_SET, WM_CLEAR
  } wr_mode_t;

  typedef struct packed {
    logic              hit;
    logic              rd;
    logic [PIDX_W-1:0] idx;
  } ptr_op_t;

  function automatic ptr_op_t ptr_decode(input logic [7:0] b);
    ptr_op_t p;
    p = '0;
    case (b)
      8'h60: begin p.hit = 1'b1; p.rd = 1'b0; p.idx = PIDX_W'(0); end
      8'h62: begin p.hit = 1'b1; p.rd = 1'b1; p.idx = PIDX_W'(0); end
      8'h64: begin p.hit = 1'b1; p.rd = 1'b0; p.idx = PIDX_W'(1); end
      8'h66: begin p.hit = 1'b1; p.rd = 1'b1; p.idx = PIDX_W'(1); end
      8'h68: begin p.hit = 1'b1; p.rd = 1'b0; p.idx = PIDX_W'(2); end
      8'h6A: begin p.hit = 1'b1; p.rd = 1'b1; p.idx = PIDX_W'(2); end
      8'h6C: begin p.hit = 1'b1; p.rd = 1'b0; p.idx = PIDX_W'(3); end
      8'h6E: begin p.hit = 1'b1; p.rd = 1'b1; p.idx = PIDX_W'(3); end
      8'h70: begin p.hit = 1'b1; p.rd = 1'b0; p.idx = PIDX_W'(4); end
      8'h72: begin p.hit = 1'b1; p.rd = 1'b1; p.idx = PIDX_W'(4); end
      8'h78: begin p.hit = 1'b1; p.rd = 1'b0; p.idx = PIDX_W'(5); end
      8'h76: begin p.hit = 1'b1; p.rd = 1'b1; p.idx = PIDX_W'(5); end
      default: p = '0;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/spi_bank_frontend.sv
// Oversampled SPI mode-0 shifter: synchronises the pins, assembles
// received bytes and serialises the byte offered by the decoder.
module spi_bank_frontend #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              mosi,
  input  logic [BYTE_W-1:0] tx_byte,
  output logic              miso,
  output logic              byte_vld,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              frame_start,
  output logic              cs_idle
);

  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic sck_m, sck_s, sck_p;
  logic cs_m, cs_s, cs_p;
  logic mosi_m, mosi_s;

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-2:0] shf_q, shf_d;
  logic [BYTE_W-1:0] rxb_q, rxb_d;
  logic [BYTE_W-1:0] tx_q, tx_d;
  logic              vld_q, vld_d;
  logic              pend_q, pend_d;
  logic              rise, fall;

  // pin synchronisers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_m <= 1'b0; sck_s <= 1'b0; sck_p <= 1'b0;
      cs_m  <= 1'b1; cs_s  <= 1'b1; cs_p  <= 1'b1;
      mosi_m <= 1'b0; mosi_s <= 1'b0;
    end else begin
      sck_m <= sck;  sck_s <= sck_m; sck_p <= sck_s;
      cs_m  <= cs_n; cs_s  <= cs_m;  cs_p  <= cs_s;
      mosi_m <= mosi; mosi_s <= mosi_m;
    end
  end

  assign rise        = !cs_s && sck_s && !sck_p;
  assign fall        = !cs_s && !sck_s && sck_p;
  assign frame_start = cs_p && !cs_s;

  always_comb begin
    cnt_d  = cnt_q;
    shf_d  = shf_q;
    rxb_d  = rxb_q;
    tx_d   = tx_q;
    vld_d  = 1'b0;
    pend_d = pend_q;
    if (cs_s) begin
      cnt_d  = '0;
      tx_d   = '0;
      pend_d = 1'b0;
    end else begin
      if (rise) begin
        shf_d = {shf_q[BYTE_W-3:0], mosi_s};
        if (cnt_q == LAST_BIT) begin
          cnt_d  = '0;
          vld_d  = 1'b1;
          rxb_d  = {shf_q, mosi_s};
          pend_d = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      if (fall) begin
        if (pend_q) begin
          tx_d   = tx_byte;
          pend_d = 1'b0;
        end else begin
          tx_d = {tx_q[BYTE_W-2:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      shf_q  <= '0;
      rxb_q  <= '0;
      tx_q   <= '0;
      vld_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      if (rise) shf_q <= shf_d;
      if (vld_d) rxb_q <= rxb_d;
      tx_q   <= tx_d;
      vld_q  <= vld_d;
      pend_q <= pend_d;
    end
  end

  assign miso     = tx_q[BYTE_W-1];
  assign byte_vld = vld_q;
  assign rx_byte  = rxb_q;
  assign cs_idle  = cs_s;

endmodule

// File: rtl/spi_bank_decode.sv
// Command sequencer: opcode decode, bank state, pointer registers and
// the per-byte access requests towards the register file.
module spi_bank_decode
  import spi_bank_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int SHARED_BASE = 22,
  parameter int BANK_W      = 2,
  parameter int PTR_W       = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              byte_vld,
  input  logic [7:0]        rx_byte,
  input  logic [7:0]        rd_byte,
  output logic [BANK_W-1:0] bank,
  output logic [ADDR_W-1:0] look_addr,
  output logic              wr_en,
  output wr_mode_t          wr_mode,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              ctl_set,
  output logic              ctl_clr,
  output logic [7:0]        tx_byte,
  output dec_state_t        state,
  output logic [ADDR_W-1:0] cur_addr
);

  localparam logic [ADDR_W-1:0] ADDR_TOP  = '1;
  localparam logic [ADDR_W-1:0] ADDR_WRAP = ADDR_W'(SHARED_BASE);

  dec_state_t         st_q, st_d;
  op_kind_t           op_q, op_d;
  logic [ADDR_W-1:0]  addr_q, addr_d, addr_inc;
  logic [PIDX_W-1:0]  pidx_q, pidx_d;
  logic [7:0]         plo_q, plo_d;
  logic [BANK_W-1:0]  bank_q, bank_d;
  logic [7:0]         txn_q, txn_d;
  logic               ptr_we;
  ptr_op_t            pd;
  logic [NUM_PTRS-1:0][PTR_W-1:0] ptr_all;

  assign addr_inc = (addr_q == ADDR_TOP) ? ADDR_WRAP : addr_q + 1'b1;
  assign pd       = ptr_decode(rx_byte);

  always_comb begin
    st_d      = st_q;
    op_d      = op_q;
    addr_d    = addr_q;
    pidx_d    = pidx_q;
    plo_d     = plo_q;
    bank_d    = bank_q;
    txn_d     = txn_q;
    look_addr = addr_q;
    wr_en     = 1'b0;
    wr_mode   = WM_WRITE;
    ctl_set   = 1'b0;
    ctl_clr   = 1'b0;
    ptr_we    = 1'b0;
    if (frame_start) begin
      st_d  = ST_OPC;
      op_d  = OP_NONE;
      txn_d = '0;
    end else if (byte_vld) begin
      txn_d = '0;
      case (st_q)
        ST_OPC: begin
          if (rx_byte[7:5] == 3'b000 || rx_byte[7:5] == 3'b010 ||
              rx_byte[7:5] == 3'b100 || rx_byte[7:5] == 3'b101) begin
            addr_d    = rx_byte[ADDR_W-1:0];
            look_addr = rx_byte[ADDR_W-1:0];
            st_d      = ST_NB;
            case (rx_byte[7:5])
              3'b000:  begin op_d = OP_RD; txn_d = rd_byte; end
              3'b010:  op_d = OP_WR;
              3'b100:  op_d = OP_SET;
              default: op_d = OP_CLR;
            endcase
          end else if ((rx_byte & OPC_BANKSEL_MASK) == OPC_BANK0) begin
            bank_d = rx_byte[BANK_W:1];
          end else if (rx_byte == OPC_RDBANK) begin
            txn_d = OPC_BANK0 | {{(7-BANK_W){1'b0}}, bank_q, 1'b0};
            st_d  = ST_RBK;
          end else if (rx_byte == OPC_CTL_SET) begin
            ctl_set = 1'b1;
          end else if (rx_byte == OPC_CTL_CLR) begin
            ctl_clr = 1'b1;
          end else if (pd.hit) begin
            pidx_d = pd.idx;
            st_d   = ST_PLO;
            if (pd.rd) begin
              op_d  = OP_PRD;
              txn_d = ptr_all[pd.idx][7:0];
            end else begin
              op_d = OP_PWR;
            end
          end else begin
            st_d = ST_IGN;
          end
        end
        ST_NB: begin
          addr_d    = addr_inc;
          look_addr = addr_inc;
          case (op_q)
            OP_RD:  txn_d = rd_byte;
            OP_WR:  begin wr_en = 1'b1; wr_mode = WM_WRITE; end
            OP_SET: begin wr_en = 1'b1; wr_mode = WM_SET; end
            OP_CLR: begin wr_en = 1'b1; wr_mode = WM_CLEAR; end
            default: ;
          endcase
        end
        ST_PLO: begin
          st_d = ST_PHI;
          if (op_q == OP_PRD) txn_d = ptr_all[pidx_q][15:8];
          else plo_d = rx_byte;
        end
        ST_PHI: begin
          st_d   = ST_IGN;
          ptr_we = (op_q == OP_PWR);
        end
        default: st_d = ST_IGN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_OPC;
      op_q   <= OP_NONE;
      addr_q <= '0;
      pidx_q <= '0;
      plo_q  <= '0;
      bank_q <= '0;
      txn_q  <= '0;
    end else begin
      st_q   <= st_d;
      op_q   <= op_d;
      addr_q <= addr_d;
      pidx_q <= pidx_d;
      plo_q  <= plo_d;
      bank_q <= bank_d;
      txn_q  <= txn_d;
    end
  end

  for (genvar p = 0; p < NUM_PTRS; p++) begin : g_ptr
    logic [PTR_W-1:0] val_q;
    logic             ld;
    assign ld = ptr_we && (pidx_q == PIDX_W'(p));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  val_q <= '0;
      else if (ld) val_q <= {rx_byte, plo_q};
    end
    assign ptr_all[p] = val_q;
  end

  assign bank     = bank_q;
  assign wr_addr  = addr_q;
  assign wr_data  = rx_byte;
  assign tx_byte  = txn_q;
  assign state    = st_q;
  assign cur_addr = addr_q;

endmodule

// File: rtl/spi_bank_regfile.sv
// Banked byte-addressed register store with a shared upper window.
module spi_bank_regfile
  import spi_bank_pkg::*;
#(
  parameter int NUM_BANKS   = 4,
  parameter int ADDR_W      = 5,
  parameter int SHARED_BASE = 22
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [$clog2(NUM_BANKS)-1:0] bank,
  input  logic [ADDR_W-1:0]            rd_addr,
  output logic [7:0]                   rd_byte,
  input  logic                         wr_en,
  input  wr_mode_t                     wr_mode,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [7:0]                   wr_data,
  input  logic                         ctl_set,
  input  logic                         ctl_clr
);

  localparam int BANK_W      = $clog2(NUM_BANKS);
  localparam int WORD_W      = 16;
  localparam int SPACE_WORDS = (2 ** ADDR_W) / 2;
  localparam int BANK_WORDS  = SHARED_BASE / 2;
  localparam int SH_WORDS    = SPACE_WORDS - BANK_WORDS;
  localparam int TOTAL       = NUM_BANKS * BANK_WORDS + SH_WORDS;
  localparam int CTRL_SLOT   = TOTAL - 1;
  localparam int SLOT_W      = $clog2(TOTAL);

  function automatic logic [SLOT_W-1:0] slot_of(input logic [BANK_W-1:0] bk,
                                                input logic [ADDR_W-1:0] a);
    int w;
    w = int'(a) / 2;
    if (int'(a) >= SHARED_BASE)
      return SLOT_W'(NUM_BANKS * BANK_WORDS + w - BANK_WORDS);
    else
      return SLOT_W'(int'(bk) * BANK_WORDS + w);
  endfunction

  logic [TOTAL-1:0][WORD_W-1:0] words;
  logic [SLOT_W-1:0]            rd_slot, wr_slot;
  logic [WORD_W-1:0]            rd_word;

  assign rd_slot = slot_of(bank, rd_addr);
  assign wr_slot = slot_of(bank, wr_addr);
  assign rd_word = words[rd_slot];
  assign rd_byte = rd_addr[0] ? rd_word[15:8] : rd_word[7:0];

  for (genvar g = 0; g < TOTAL; g++) begin : g_word
    localparam bit IS_CTRL = (g == CTRL_SLOT);
    logic [WORD_W-1:0] val_q, val_d;
    logic [7:0]        old_b, new_b;
    logic              en;

    always_comb begin
      val_d = val_q;
      en    = 1'b0;
      old_b = wr_addr[0] ? val_q[15:8] : val_q[7:0];
      case (wr_mode)
        WM_SET:   new_b = old_b | wr_data;
        WM_CLEAR: new_b = old_b & ~wr_data;
        default:  new_b = wr_data;
      endcase
      if (wr_en && wr_slot == SLOT_W'(g)) begin
        en = 1'b1;
        if (wr_addr[0]) val_d[15:8] = new_b;
        else            val_d[7:0]  = new_b;
      end
      if (IS_CTRL && (ctl_set || ctl_clr)) begin
        en       = 1'b1;
        val_d[0] = ctl_set;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  val_q <= '0;
      else if (en) val_q <= val_d;
    end

    assign words[g] = val_q;
  end

endmodule

// File: rtl/spi_bank_cmd.sv
module spi_bank_cmd
  import spi_bank_pkg::*;
#(
  parameter int NUM_BANKS   = 4,
  parameter int ADDR_W      = 5,
  parameter int SHARED_BASE = 22
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck,
  input  logic cs_n,
  input  logic mosi,
  output logic miso
);

  localparam int BANK_W = $clog2(NUM_BANKS);

  logic [1:0]        rst_sync_q;
  logic              rst_core_n;
  logic              byte_vld, frame_start, cs_idle;
  logic [7:0]        rx_byte, tx_byte, rd_byte, wr_data;
  logic [BANK_W-1:0] bank;
  logic [ADDR_W-1:0] look_addr, wr_addr, cur_addr;
  logic              wr_en, ctl_set, ctl_clr;
  wr_mode_t          wr_mode;
  dec_state_t        dec_state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  spi_bank_frontend #(.BYTE_W(8)) u_fe (
    .clk(clk), .rst_n(rst_core_n), .sck(sck), .cs_n(cs_n), .mosi(mosi),
    .tx_byte(tx_byte), .miso(miso), .byte_vld(byte_vld), .rx_byte(rx_byte),
    .frame_start(frame_start), .cs_idle(cs_idle)
  );

  spi_bank_decode #(
    .ADDR_W(ADDR_W), .SHARED_BASE(SHARED_BASE), .BANK_W(BANK_W), .PTR_W(16)
  ) u_dec (
    .clk(clk), .rst_n(rst_core_n), .frame_start(frame_start),
    .byte_vld(byte_vld), .rx_byte(rx_byte), .rd_byte(rd_byte), .bank(bank),
    .look_addr(look_addr), .wr_en(wr_en), .wr_mode(wr_mode),
    .wr_addr(wr_addr), .wr_data(wr_data), .ctl_set(ctl_set),
    .ctl_clr(ctl_clr), .tx_byte(tx_byte), .state(dec_state),
    .cur_addr(cur_addr)
  );

  spi_bank_regfile #(
    .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .SHARED_BASE(SHARED_BASE)
  ) u_rf (
    .clk(clk), .rst_n(rst_core_n), .bank(bank), .rd_addr(look_addr),
    .rd_byte(rd_byte), .wr_en(wr_en), .wr_mode(wr_mode), .wr_addr(wr_addr),
    .wr_data(wr_data), .ctl_set(ctl_set), .ctl_clr(ctl_clr)
  );

endmodule

// File: rtl/spi_bank_cmd_chk.sv
module spi_bank_cmd_chk
  import spi_bank_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int SHARED_BASE = 22,
  parameter int BANK_W      = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_idle,
  input logic              miso,
  input logic              frame_start,
  input logic              byte_vld,
  input logic [BANK_W-1:0] bank,
  input logic [2:0]        dec_state,
  input logic [ADDR_W-1:0] cur_addr,
  input logic              wr_en,
  input logic              ctl_set,
  input logic              ctl_clr
);

  // R1
  miso_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_idle && $past(cs_idle)) |-> !miso);

  // R1
  opcode_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (dec_state == 3'(ST_OPC)));

  // R2
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_vld |=> $stable(bank));

  // R6
  shared_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_vld && !frame_start && dec_state == 3'(ST_NB) &&
     int'(cur_addr) >= SHARED_BASE) |=> (int'(cur_addr) >= SHARED_BASE));

  // R10
  ignore_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_state == 3'(ST_IGN) && !frame_start) |-> !(wr_en || ctl_set || ctl_clr));

  // R9
  single_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_en, ctl_set, ctl_clr}));

endmodule

bind spi_bank_cmd spi_bank_cmd_chk #(
  .ADDR_W(ADDR_W), .SHARED_BASE(SHARED_BASE), .BANK_W(BANK_W)
) u_chk (
  .clk(clk), .rst_n(rst_core_n), .cs_idle(cs_idle), .miso(miso),
  .frame_start(frame_start), .byte_vld(byte_vld), .bank(bank),
  .dec_state(dec_state), .cur_addr(cur_addr), .wr_en(wr_en),
  .ctl_set(ctl_set), .ctl_clr(ctl_clr)
);

// File: tb/sim_spi_bank_cmd.sv
`timescale 1ns/1ps
module sim_spi_bank_cmd;

  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0;
  logic cs_n = 1'b1;
  logic mosi = 1'b0;
  logic miso;

  always #2.5 clk = ~clk;

  spi_bank_cmd u0 (.clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n),
                   .mosi(mosi), .miso(miso));

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  // reference model
  logic [15:0] m_bank [4][11];
  logic [15:0] m_sh [5];
  logic [15:0] m_ptr [6];
  int          m_bk;

  function automatic logic [7:0] m_rd(input int bk, input int a);
    logic [15:0] w;
    if (a >= 22) w = m_sh[(a / 2) - 11];
    else         w = m_bank[bk][a / 2];
    return (a % 2 == 1) ? w[15:8] : w[7:0];
  endfunction

  function automatic void m_wr(input int bk, input int a, input int mode,
                               input logic [7:0] d);
    logic [15:0] w;
    logic [7:0]  o, n;
    if (a >= 22) w = m_sh[(a / 2) - 11];
    else         w = m_bank[bk][a / 2];
    o = (a % 2 == 1) ? w[15:8] : w[7:0];
    if (mode == 1)      n = o | d;
    else if (mode == 2) n = o & ~d;
    else                n = d;
    if (a % 2 == 1) w[15:8] = n; else w[7:0] = n;
    if (a >= 22) m_sh[(a / 2) - 11] = w;
    else         m_bank[bk][a / 2] = w;
  endfunction

  function automatic int nxt(input int a);
    return (a == 31) ? 22 : a + 1;
  endfunction

  function automatic logic [7:0] pw_opc(input int i);
    case (i)
      0: return 8'h60; 1: return 8'h64; 2: return 8'h68;
      3: return 8'h6C; 4: return 8'h70; default: return 8'h78;
    endcase
  endfunction

  function automatic logic [7:0] pr_opc(input int i);
    case (i)
      0: return 8'h62; 1: return 8'h66; 2: return 8'h6A;
      3: return 8'h6E; 4: return 8'h72; default: return 8'h76;
    endcase
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer_bits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
    rx = '0;
    for (int i = 0; i < nb; i++) begin
      mosi = tx[7-i];
      wait_clk(HALF);
      rx[7-i] = miso;
      sck = 1'b1;
      wait_clk(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    xfer_bits(tx, 8, rx);
  endtask

  task automatic fbeg();
    cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic fend();
    wait_clk(HALF);
    cs_n = 1'b1;
    wait_clk(2 * HALF);
  endtask

  // full read-back of one bank through an N-byte read from address 0
  task automatic dump_bank(input int bk);
    logic [7:0] r;
    int a;
    fbeg();
    xfer(8'hC0 | 8'(bk * 2), r);
    xfer(8'h00, r);
    chk("R1 opcode byte returns zero", r, 8'h00);
    m_bk = bk;
    a = 0;
    for (int i = 0; i < 32; i++) begin
      xfer(8'hA5, r);
      chk((a >= 22) ? "R7 shared dump" : "R4 bank dump", r, m_rd(bk, a));
      a = nxt(a);
    end
    fend();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] r, r2, d;
    int a, k, n, idx, op;
    for (int b = 0; b < 4; b++) for (int w = 0; w < 11; w++) m_bank[b][w] = '0;
    for (int w = 0; w < 5; w++) m_sh[w] = '0;
    for (int p = 0; p < 6; p++) m_ptr[p] = '0;
    m_bk = 0;
    void'($urandom(32'd4242));
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);

    // R11 / R2: reset state
    chk("R1 miso idle", {7'd0, miso}, 8'h00);
    fbeg(); xfer(8'hC8, r); xfer(8'h00, r2); fend();
    chk("R1 opcode returns zero", r, 8'h00);
    chk("R2 bank 0 after reset", r2, 8'hC0);
    fbeg(); xfer(8'h6E, r); xfer(8'h00, r); xfer(8'h00, r2); fend();
    chk("R11 pointer low after reset", r, 8'h00);
    chk("R11 pointer high after reset", r2, 8'h00);

    // R2 / R3: chained select then bank read, trailing byte ignored
    fbeg(); xfer(8'hC2, r); xfer(8'hC4, r); xfer(8'hC8, r);
    xfer(8'h00, r); xfer(8'hC0, r2); fend();
    chk("R3 bank read after chain", r, 8'hC4);
    chk("R3 trailing byte zero", r2, 8'h00);
    fbeg(); xfer(8'hC8, r); xfer(8'h00, r); fend();
    chk("R2 bank persists across frames", r, 8'hC4);
    m_bk = 2;

    // R7: private vs shared
    fbeg(); xfer(8'h44, r); xfer(8'h5A, r); fend();
    m_wr(2, 4, 0, 8'h5A);
    fbeg(); xfer(8'hC2, r); xfer(8'h04, r); xfer(8'h00, r); fend();
    chk("R7 private byte not seen in bank 1", r, 8'h00);
    fbeg(); xfer(8'h5A, r); xfer(8'h77, r); fend();
    m_wr(1, 26, 0, 8'h77);
    fbeg(); xfer(8'hC6, r); xfer(8'h1A, r); xfer(8'h00, r); fend();
    chk("R7 shared byte seen in bank 3", r, 8'h77);
    fbeg(); xfer(8'hC4, r); xfer(8'h04, r); xfer(8'h00, r); fend();
    chk("R4 bank 2 byte kept", r, 8'h5A);
    m_bk = 2;

    // R6: wrap 0x1F -> 0x16
    fbeg(); xfer(8'h5E, r); xfer(8'h11, r); xfer(8'h22, r); xfer(8'h33, r); fend();
    m_wr(2, 30, 0, 8'h11); m_wr(2, 31, 0, 8'h22); m_wr(2, 22, 0, 8'h33);
    fbeg(); xfer(8'h1F, r); xfer(8'h00, r); xfer(8'h00, r2); fend();
    chk("R6 read at 0x1F", r, 8'h22);
    chk("R6 wrap lands on 0x16", r2, 8'h33);

    // R5: set and clear
    fbeg(); xfer(8'h48, r); xfer(8'hF0, r); fend();
    fbeg(); xfer(8'h88, r); xfer(8'h0F, r); fend();
    fbeg(); xfer(8'h08, r); xfer(8'h00, r); fend();
    chk("R5 set ORs bits", r, 8'hFF);
    fbeg(); xfer(8'hA8, r); xfer(8'h3C, r); fend();
    fbeg(); xfer(8'h08, r); xfer(8'h00, r); fend();
    chk("R5 clear removes bits", r, 8'hC3);
    m_wr(2, 8, 0, 8'hC3);

    // R9: control bit set/clear, chained with bank read
    fbeg(); xfer(8'hE8, r); xfer(8'hC8, r); xfer(8'h00, r2); fend();
    chk("R9 chain after control set", r2, 8'hC4);
    m_sh[4][0] = 1'b1;
    fbeg(); xfer(8'h1E, r); xfer(8'h00, r); fend();
    chk("R9 control bit set", r, m_rd(2, 30));
    fbeg(); xfer(8'hEA, r); xfer(8'h1E, r); xfer(8'h00, r); fend();
    m_sh[4][0] = 1'b0;
    chk("R9 control bit cleared", r, m_rd(2, 30));

    // R8: last pointer has swapped opcodes
    fbeg(); xfer(8'h78, r); xfer(8'hCD, r); xfer(8'hAB, r); fend();
    m_ptr[5] = 16'hABCD;
    fbeg(); xfer(8'h76, r); xfer(8'h00, r); xfer(8'h00, r2); fend();
    chk("R8 pointer low first", r, 8'hCD);
    chk("R8 pointer high second", r2, 8'hAB);

    // R12: aborts
    fbeg(); xfer(8'h60, r); xfer(8'h99, r); fend();
    fbeg(); xfer(8'h62, r); xfer(8'h00, r); xfer(8'h00, r2); fend();
    chk("R12 partial pointer not committed lo", r, 8'h00);
    chk("R12 partial pointer not committed hi", r2, 8'h00);
    fbeg(); xfer(8'h45, r); xfer_bits(8'hFF, 4, r); fend();
    fbeg(); xfer(8'h05, r); xfer(8'h00, r); fend();
    chk("R12 half byte dropped", r, m_rd(2, 5));

    // R10: unknown opcode
    fbeg(); xfer(8'hCA, r); xfer(8'h4F, r); xfer(8'h00, r2); fend();
    chk("R10 unknown opcode answer", r, 8'h00);
    chk("R10 unknown opcode trailing", r2, 8'h00);
    fbeg(); xfer(8'h0F, r); xfer(8'h00, r); fend();
    chk("R10 no write from unknown", r, m_rd(2, 15));

    // constrained random frames
    for (int it = 0; it < 90; it++) begin
      k = $urandom % 6;
      fbeg();
      case (k)
        0: begin
          n = 1 + ($urandom % 3);
          for (int j = 0; j < n; j++) begin
            idx = $urandom % 6;
            if (idx < 4) begin d = 8'hC0 | 8'(idx * 2); m_bk = idx; end
            else if (idx == 4) begin d = 8'hE8; m_sh[4][0] = 1'b1; end
            else begin d = 8'hEA; m_sh[4][0] = 1'b0; end
            xfer(d, r);
          end
          xfer(8'hC8, r); xfer(8'h00, r);
          chk("R2 random bank chain", r, 8'hC0 | 8'(m_bk * 2));
        end
        1: begin
          a = $urandom % 32; n = 1 + ($urandom % 4);
          xfer(8'(a), r);
          for (int j = 0; j < n; j++) begin
            xfer(8'($urandom), r);
            chk("R4 random read", r, m_rd(m_bk, a));
            a = nxt(a);
          end
        end
        2: begin
          a = $urandom % 32; n = 1 + ($urandom % 3); op = $urandom % 3;
          xfer(((op == 0) ? 8'h40 : (op == 1) ? 8'h80 : 8'hA0) | 8'(a), r);
          for (int j = 0; j < n; j++) begin
            d = 8'($urandom);
            xfer(d, r);
            m_wr(m_bk, a, op, d);
            a = nxt(a);
          end
        end
        3: begin
          idx = $urandom % 6;
          if ($urandom % 2 == 0) begin
            d = 8'($urandom); r2 = 8'($urandom);
            xfer(pw_opc(idx), r); xfer(d, r); xfer(r2, r);
            m_ptr[idx] = {r2, d};
          end else begin
            xfer(pr_opc(idx), r); xfer(8'h00, r); xfer(8'h00, r2);
            chk("R8 random pointer lo", r, m_ptr[idx][7:0]);
            chk("R8 random pointer hi", r2, m_ptr[idx][15:8]);
            xfer(8'h00, r);
            chk("R8 byte after pointer zero", r, 8'h00);
          end
        end
        4: begin
          idx = $urandom % 6;
          case (idx)
            0: d = 8'h20; 1: d = 8'h28; 2: d = 8'hCA;
            3: d = 8'h74; 4: d = 8'hFF; default: d = 8'hD4;
          endcase
          xfer(d, r);
          for (int j = 0; j < 2; j++) begin
            xfer(8'($urandom), r);
            chk("R10 random unknown zero", r, 8'h00);
          end
        end
        default: begin
          if ($urandom % 2 == 0) begin
            idx = $urandom % 6;
            xfer(pw_opc(idx), r); xfer(8'($urandom), r);
          end else begin
            xfer(8'h40 | 8'($urandom % 32), r);
            xfer_bits(8'($urandom), 1 + ($urandom % 7), r);
          end
        end
      endcase
      fend();
    end

    for (int b = 0; b < 4; b++) dump_bank(b);
    for (int p = 0; p < 6; p++) begin
      fbeg(); xfer(pr_opc(p), r); xfer(8'h00, r); xfer(8'h00, r2); fend();
      chk("R8 final pointer lo", r, m_ptr[p][7:0]);
      chk("R8 final pointer hi", r2, m_ptr[p][15:8]);
    end
    finish_run();
  end

endmodule